// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This combinational block decides, for every logical access, whether the access skips paged translation entirely. It compares the top byte of a 32-bit logical address and the 3-bit function code of the access against two window registers. When any enabled window matches, or when the access is in CPU space, the block raises a bypass flag. In that case the physical address is the logical address unchanged.

Two register layouts exist, and a parameter picks one at elaboration. The legacy layout qualifies the function code with a base field and a per-bit ignore field. The split layout uses a 2-bit mode selector to qualify the function code. It also carries a write-protect bit: a write that hits such a window raises a fault, unless the access is a probe.

Top module: `ttw_bypass`

## Requirements
- R1: A window register takes part only when its bit 15 is 1. With bit 15 at 0 that window never causes a bypass or a fault, whatever its other bits hold.
- R2: The window base is bits 31:24 and the ignore mask is bits 23:16, where a 1 in the mask ignores that address bit. The address condition holds when (la[31:24] AND NOT mask) equals the base. A base bit set under a mask bit therefore makes the window unmatchable.
- R3: In the legacy layout (FMT = TTW_LEGACY), the function code condition is (fc AND NOT reg[2:0]) == reg[6:4].
- R4: In the split layout (FMT = TTW_SPLIT), reg[14:13] selects the function code condition: 00 requires fc[2]=0, 01 requires fc[2]=1, and 10 or 11 accepts any fc.
- R5: Function code 7 always sets bypass, even with both windows disabled.
- R6: A match on either window alone is enough to set bypass. Without a match and with fc not 7, bypass is 0.
- R7: While bypass is 1, pa equals la bit for bit.
- R8: In the split layout, a matching window with reg[2]=1 raises wp_fault on a write (acc_read=0). A probe (probe=1) suppresses it, and reads never fault.
- R9: wp_fault is never 1 while bypass is 0. When both windows match, wp_fault is the OR of the two windows' write-protect checks.
- R10: In the legacy layout wp_fault is always 0, and reg[2] acts only as a function code ignore bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| la | input | 32 | Logical address of the access |
| fc | input | 3 | Function code of the access |
| acc_read | input | 1 | 1 for a read, 0 for a write |
| probe | input | 1 | Access is a translation probe; suppresses write-protect faults |
| ttr_a | input | 32 | Window register 0 |
| ttr_b | input | 32 | Window register 1 |
| bypass | output | 1 | Access skips paged translation |
| wp_fault | output | 1 | Write hit a write-protected window |
| pa | output | 32 | Physical address, equal to la when bypass is 1 |

## Verification
The bench builds two copies at the default widths, one with FMT = TTW_LEGACY and one with FMT = TTW_SPLIT, and feeds both the same stimulus. Every combination of the low seven register bits is swept against all eight function codes, so the legacy base/ignore arithmetic and fc 7 are covered in full. Address bases and masks are chosen so that exact hits, masked hits, near misses and unmatchable windows all occur. The split copy is also swept over every mode, write-protect setting, read/write and probe combination, and window pairs are crossed to reach the single-hit, double-hit and fault-OR cases.

// File: rtl/ttw_pkg.sv
package ttw_pkg;

  typedef enum logic [0:0] {
    TTW_LEGACY = 1'b0,
    TTW_SPLIT  = 1'b1
  } ttw_fmt_e;

  // Field positions that the matching logic decodes.
  localparam int TTW_EN_BIT    = 15;
  localparam int TTW_MODE_LSB  = 13;
  localparam int TTW_WP_BIT    = 2;
  localparam int TTW_FCB_LSB   = 4;
  localparam int TTW_FCM_LSB   = 0;

  // Split-layout function code modes.
  localparam logic [1:0] TTW_MODE_USER = 2'b00;
  localparam logic [1:0] TTW_MODE_SUPV = 2'b01;

endpackage

// File: rtl/ttw_addr_cmp.sv
module ttw_addr_cmp #(
  parameter int ADDR_W = 32,
  parameter int WIN_W  = 8
) (
  input  logic [ADDR_W-1:0] la,
  input  logic [WIN_W-1:0]  base,
  input  logic [WIN_W-1:0]  ign,
  output logic              hit
);
  logic [WIN_W-1:0] top;
  logic [WIN_W-1:0] kept;

  always_comb begin
    top  = la[ADDR_W-1 -: WIN_W];
    kept = top & ~ign;
    hit  = (kept == base);
  end

  logic low_unused;
  assign low_unused = ^la[ADDR_W-WIN_W-1:0];

endmodule

// File: rtl/ttw_fc_qual.sv
module ttw_fc_qual
  import ttw_pkg::*;
#(
  parameter ttw_fmt_e FMT  = TTW_LEGACY,
  parameter int       FC_W = 3
) (
  input  logic [FC_W-1:0] fc,
  input  logic [15:0]     ctl,
  output logic            ok
);
  generate
    if (FMT == TTW_LEGACY) begin : g_legacy
      logic [FC_W-1:0] fc_ign;
      logic [FC_W-1:0] fc_base;
      always_comb begin
        fc_ign  = ctl[TTW_FCM_LSB +: FC_W];
        fc_base = ctl[TTW_FCB_LSB +: FC_W];
        ok      = ((fc & ~fc_ign) == fc_base);
      end
    end else begin : g_split
      logic [1:0] mode;
      logic       supv;
      always_comb begin
        mode = ctl[TTW_MODE_LSB +: 2];
        supv = fc[FC_W-1];
        case (mode)
          TTW_MODE_USER: ok = ~supv;
          TTW_MODE_SUPV: ok = supv;
          default:       ok = 1'b1;
        endcase
      end
    end
  endgenerate

  logic ctl_unused;
  assign ctl_unused = ^ctl;

endmodule

// File: rtl/ttw_window.sv
module ttw_window
  import ttw_pkg::*;
#(
  parameter ttw_fmt_e FMT    = TTW_LEGACY,
  parameter int       ADDR_W = 32,
  parameter int       WIN_W  = 8,
  parameter int       FC_W   = 3
) (
  input  logic [ADDR_W-1:0] la,
  input  logic [FC_W-1:0]   fc,
  input  logic              acc_read,
  input  logic              probe,
  input  logic [ADDR_W-1:0] ttr,
  output logic              hit,
  output logic              fault
);
  localparam int BASE_LSB = ADDR_W - WIN_W;
  localparam int IGN_LSB  = ADDR_W - 2 * WIN_W;

  logic addr_ok;
  logic fc_ok;
  logic en;

  ttw_addr_cmp #(
    .ADDR_W (ADDR_W),
    .WIN_W  (WIN_W)
  ) u_addr (
    .la   (la),
    .base (ttr[BASE_LSB +: WIN_W]),
    .ign  (ttr[IGN_LSB +: WIN_W]),
    .hit  (addr_ok)
  );

  ttw_fc_qual #(
    .FMT  (FMT),
    .FC_W (FC_W)
  ) u_fc (
    .fc  (fc),
    .ctl (ttr[15:0]),
    .ok  (fc_ok)
  );

  always_comb begin
    en  = ttr[TTW_EN_BIT];
    hit = en & addr_ok & fc_ok;
  end

  generate
    if (FMT == TTW_SPLIT) begin : g_wp
      always_comb fault = hit & ttr[TTW_WP_BIT] & ~acc_read & ~probe;
    end else begin : g_nowp
      logic acc_unused;
      assign acc_unused = acc_read ^ probe;
      always_comb fault = 1'b0;
    end
  endgenerate

  // Window checks
  always_comb begin
    p_disabled_silent_r1: assert (ttr[TTW_EN_BIT] || (!hit && !fault))
      else $error("disabled window produced hit or fault");
    p_probe_blocks_fault_r8: assert (!probe || !fault)
      else $error("fault raised during probe");
    p_read_never_faults_r8: assert (!acc_read || !fault)
      else $error("fault raised on read");
  end

endmodule

// File: rtl/ttw_bypass.sv
module ttw_bypass
  import ttw_pkg::*;
#(
  parameter ttw_fmt_e FMT    = TTW_LEGACY,
  parameter int       ADDR_W = 32,
  parameter int       WIN_W  = 8,
  parameter int       FC_W   = 3
) (
  input  logic [ADDR_W-1:0] la,
  input  logic [FC_W-1:0]   fc,
  input  logic              acc_read,
  input  logic              probe,
  input  logic [ADDR_W-1:0] ttr_a,
  input  logic [ADDR_W-1:0] ttr_b,
  output logic              bypass,
  output logic              wp_fault,
  output logic [ADDR_W-1:0] pa
);
  localparam int              NUM_WIN = 2;
  localparam logic [FC_W-1:0] FC_CPU  = {FC_W{1'b1}};

  logic [ADDR_W-1:0]  ttr_v   [NUM_WIN];
  logic [NUM_WIN-1:0] hit_v;
  logic [NUM_WIN-1:0] fault_v;
  logic               cpu_space;

  assign ttr_v[0] = ttr_a;
  assign ttr_v[1] = ttr_b;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    ttw_window #(
      .FMT    (FMT),
      .ADDR_W (ADDR_W),
      .WIN_W  (WIN_W),
      .FC_W   (FC_W)
    ) u_win (
      .la       (la),
      .fc       (fc),
      .acc_read (acc_read),
      .probe    (probe),
      .ttr      (ttr_v[w]),
      .hit      (hit_v[w]),
      .fault    (fault_v[w])
    );
  end

  always_comb begin
    cpu_space = (fc == FC_CPU);
    bypass    = cpu_space | (|hit_v);
    wp_fault  = |fault_v;
    pa        = la;
  end

  // Output relation checks
  always_comb begin
    p_fault_needs_bypass_r9: assert (!wp_fault || bypass)
      else $error("fault without bypass");
    p_pass_through_r7: assert (!bypass || (pa == la))
      else $error("pa differs from la under bypass");
    p_cpu_space_r5: assert (!cpu_space || bypass)
      else $error("cpu space not bypassed");
    p_any_hit_bypasses_r6: assert ((hit_v == '0) || bypass)
      else $error("window hit without bypass");
  end

endmodule

// File: tb/tb_ttw_bypass.sv
module tb_ttw_bypass;
  import ttw_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] la;
  logic [2:0]  fc;
  logic        acc_read, probe;
  logic [31:0] ttr_a, ttr_b;
  logic        byp_l, flt_l, byp_s, flt_s;
  logic [31:0] pa_l, pa_s;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  ttw_bypass #(.FMT(TTW_LEGACY)) dut (
    .la(la), .fc(fc), .acc_read(acc_read), .probe(probe),
    .ttr_a(ttr_a), .ttr_b(ttr_b),
    .bypass(byp_l), .wp_fault(flt_l), .pa(pa_l));

  ttw_bypass #(.FMT(TTW_SPLIT)) dut_wp (
    .la(la), .fc(fc), .acc_read(acc_read), .probe(probe),
    .ttr_a(ttr_a), .ttr_b(ttr_b),
    .bypass(byp_s), .wp_fault(flt_s), .pa(pa_s));

  // R1 R2 R3 R4 model of one window
  function automatic bit win_hit(input bit split, input logic [31:0] r,
                                 input logic [31:0] a, input logic [2:0] f);
    if (!r[15]) return 1'b0;
    if ((a[31:24] & ~r[23:16]) != r[31:24]) return 1'b0;
    if (!split) return ((f & ~r[2:0]) == r[6:4]);
    case (r[14:13])
      2'b00:   return !f[2];
      2'b01:   return f[2];
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit win_fault(input bit split, input logic [31:0] r,
                                   input logic [31:0] a, input logic [2:0] f,
                                   input bit rd, input bit pr);
    return split && win_hit(split, r, a, f) && r[2] && !rd && !pr;
  endfunction

  task automatic check_one(input bit split, input string tag,
                           input bit byp, input bit flt, input logic [31:0] p);
    bit eb, ef;
    eb = (fc == 3'd7) || win_hit(split, ttr_a, la, fc) || win_hit(split, ttr_b, la, fc);
    ef = win_fault(split, ttr_a, la, fc, acc_read, probe) ||
         win_fault(split, ttr_b, la, fc, acc_read, probe);
    if (byp !== eb || flt !== ef || (eb && p !== la)) begin
      n_fail++;
      if (n_fail < 20)
        $display("FAIL %s fmt=%0d la=%h fc=%0d rd=%0d pr=%0d a=%h b=%h : byp=%0d flt=%0d pa=%h exp byp=%0d flt=%0d pa=%h",
                 tag, split, la, fc, acc_read, probe, ttr_a, ttr_b, byp, flt, p, eb, ef, la);
    end
  endtask

  task automatic apply(input string tag);
    @(negedge clk);
    n_vec++;
    check_one(1'b0, tag, byp_l, flt_l, pa_l);
    check_one(1'b1, tag, byp_s, flt_s, pa_s);
    @(posedge clk);
  endtask

  function automatic logic [31:0] pick_addr(input int k);
    logic [7:0] tops [4] = '{8'h40, 8'h41, 8'h43, 8'hC0};
    return {tops[k], 24'h5AA53C ^ 24'(k * 24'h010203)};
  endfunction

  function automatic logic [31:0] mk_reg(input bit en, input logic [7:0] base,
                                         input logic [7:0] ign, input logic [1:0] mode,
                                         input logic [6:0] low);
    return {base, ign, en, mode, 6'b0, low};
  endfunction

  initial begin
    logic [7:0] bases [2] = '{8'h40, 8'h41};
    logic [7:0] masks [2] = '{8'h00, 8'h83};
    logic [31:0] cfg [8];
    la = '0; fc = '0; acc_read = 1'b1; probe = 1'b0; ttr_a = '0; ttr_b = '0;
    repeat (2) @(posedge clk);

    // Idle state: all windows cleared, user data access -> no bypass (R6)
    apply("R6 idle");

    // R1: disabled window with every low field and fc
    for (int lo = 0; lo < 128; lo++)
      for (int f = 0; f < 8; f++)
        for (int k = 0; k < 4; k += 3) begin
          ttr_a = mk_reg(1'b0, 8'h40, 8'h00, 2'(lo), 7'(lo) | 7'h04);
          ttr_b = '0; la = pick_addr(k); fc = 3'(f);
          acc_read = 1'b0; probe = 1'b0;
          apply("R1 disabled");
        end

    // R2 R3 R5 R10: full sweep of low seven bits, legacy fields
    for (int bi = 0; bi < 2; bi++)
      for (int mi = 0; mi < 2; mi++)
        for (int lo = 0; lo < 128; lo++)
          for (int f = 0; f < 8; f++)
            for (int k = 0; k < 4; k++) begin
              ttr_a = mk_reg(1'b1, bases[bi], masks[mi], 2'b00, 7'(lo));
              ttr_b = '0; la = pick_addr(k); fc = 3'(f);
              acc_read = 1'b0; probe = 1'b0;
              apply("R2 R3 R5 R10 window");
            end

    // R4 R8: split modes, write protect, read/write, probe
    for (int md = 0; md < 4; md++)
      for (int wp = 0; wp < 2; wp++)
        for (int bi = 0; bi < 2; bi++)
          for (int mi = 0; mi < 2; mi++)
            for (int f = 0; f < 8; f++)
              for (int k = 0; k < 4; k++)
                for (int rp = 0; rp < 4; rp++) begin
                  ttr_a = mk_reg(1'b1, bases[bi], masks[mi], 2'(md), wp ? 7'h04 : 7'h00);
                  ttr_b = '0; la = pick_addr(k); fc = 3'(f);
                  acc_read = rp[0]; probe = rp[1];
                  apply("R4 R8 split");
                end

    // R6 R7 R9: pairs of windows, single and double hits, fault OR
    cfg[0] = '0;
    cfg[1] = mk_reg(1'b1, 8'h40, 8'h00, 2'b10, 7'h04);
    cfg[2] = mk_reg(1'b1, 8'hC0, 8'h00, 2'b01, 7'h00);
    cfg[3] = mk_reg(1'b1, 8'h40, 8'h83, 2'b00, 7'h04);
    cfg[4] = mk_reg(1'b1, 8'h41, 8'h00, 2'b11, 7'h00);
    cfg[5] = mk_reg(1'b1, 8'h40, 8'h03, 2'b01, 7'h77);
    cfg[6] = mk_reg(1'b0, 8'h40, 8'hFF, 2'b10, 7'h04);
    cfg[7] = mk_reg(1'b1, 8'h00, 8'hFF, 2'b10, 7'h00);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int f = 0; f < 8; f++)
          for (int k = 0; k < 4; k++)
            for (int rd = 0; rd < 2; rd++) begin
              ttr_a = cfg[i]; ttr_b = cfg[j];
              la = pick_addr(k); fc = 3'(f);
              acc_read = rd[0]; probe = 1'b0;
              apply("R6 R7 R9 pair");
            end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: got %0d vectors, expected completion", n_vec);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule